// File: doc/BRIEF.md
# Fixed-Priority Preemptive Interrupt Controller

This block gathers thirty-two external interrupt inputs and one timer event into a single interrupt request towards a processor, together with the vector of the line being presented. Vectors are hard-wired: line n is always reported as vector 32 + n, and a larger vector always wins. The controller keeps a pending bit and an in-service bit for every line. A newly pending line is presented only if its vector is above every vector already in service. The processor takes an interrupt with an acknowledge pulse and retires it by writing the end-of-interrupt register.

Software reaches the controller over a simple register bus with byte addresses, write and read strobes, and read data that arrives one cycle after the read strobe. Per-line settings are the mask bit and the trigger mode. They are not mapped directly. Software first writes an encoded line select to the select register at 0x00, then accesses that line through the window register at 0x04. The end-of-interrupt register sits at 0x08, the in-service register at 0x0C, and the timer routing register at 0x10. Any other address reads as zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `irq_req` is high, `irq_vector` equals 32 plus the index of the presented line.
- R2: After reset, `irq_req` is low and the in-service register reads 0. Every line entry reads 0x1 (masked, edge mode). The timer register reads 0x0001_0000 (timer masked, line 0).
- R3: Suppose a line is pending and unmasked, and its vector is above every in-service vector. Then `irq_req` rises with that line's vector, even while a lower line is in service.
- R4: A pending line at or below the highest in-service vector is not presented. It stays pending and is presented after end-of-interrupt writes have cleared every higher in-service bit.
- R5: A write to 0x08, with any data, clears only the highest set in-service bit.
- R6: A read of 0x0C returns the in-service bits, with bit n for line n.
- R7: The select value for line n is ((n & 0x0F) << 1) | ((n & 0xF0) << 2). A select with bit 0 set, bit 5 set, any bit above 11 set, or a decoded line of 32 or more is invalid. Window writes through an invalid select are ignored. Window reads through an invalid select return 0. The select register itself reads back as written.
- R8: Window bit 0 is the line mask, with 1 meaning masked. A masked line is never presented. A rising edge that arrives while the line is masked is not remembered.
- R9: Window bit 1 selects the trigger mode, with 0 meaning edge. In edge mode, a rising edge on an unmasked input makes the line pending. The line stays pending after the input falls, until it is acknowledged.
- R10: In level mode, the line is pending exactly while its input is high and the line is unmasked. If the input drops before acknowledge, the request is withdrawn.
- R11: An `irq_ack` pulse while `irq_req` is high moves the presented line from pending to in-service on that clock edge. `irq_req` is low in the following cycle.
- R12: In register 0x10, bits 3:0 choose the timer line and bit 16 is the timer mask. When the timer is unmasked, a `timer_evt` pulse makes that line pending. When the timer is masked, pulses are ignored. The external input and the window mask of the timer line have no effect.
- R13: Unimplemented bits read as zero. The window uses only bits 1:0, and the timer register only bits 16 and 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | External interrupt lines |
| timer_evt | input | 1 | Timer event pulse from the external countdown |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vector | output | 8 | Vector of the presented line |
| irq_ack | input | 1 | Processor acknowledge pulse |

## Verification
The hardest situation to reach is a nest of two in-service levels with a third, lower line held pending behind them. In that state, each end-of-interrupt write must remove only the top bit, and the held line may appear only after the last higher bit is gone. The bench gets there by acknowledging line 5 first and then raising line 20 so that it preempts. Line 2 is pulsed in between. The bench then retires the two in-service lines one write at a time and checks the request and the in-service register after each write. The timer line is also exercised with its external input toggling, to show that the input is overridden.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h04;
  localparam logic [7:0] OFS_EOI = 8'h08;
  localparam logic [7:0] OFS_ISR = 8'h0C;
  localparam logic [7:0] OFS_TMR = 8'h10;
  localparam int TMR_MASK_BIT = 16;
  localparam int WIN_MASK_BIT = 0;
  localparam int WIN_LVL_BIT  = 1;
endpackage

// File: rtl/icc_regs.sv
module icc_regs #(
  parameter int NLINES = 32,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int TSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  input  logic              re,
  input  logic [NLINES-1:0] isr,
  output logic [DW-1:0]     rdata,
  output logic [NLINES-1:0] ent_mask,
  output logic [NLINES-1:0] ent_lvl,
  output logic              tmr_mask,
  output logic [TSEL_W-1:0] tmr_line,
  output logic              eoi
);
  import icc_pkg::*;
  localparam int LW   = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int IDXW = 10;

  logic [DW-1:0]     sel_q;
  logic [IDXW-1:0]   dec_idx;
  logic              sel_ok;
  logic [LW-1:0]     wline;
  logic              win_wr;
  logic [DW-1:0]     rd_c;

  // select decode: low nibble sits at bits 4:1, upper bits at 11:6
  assign dec_idx = {sel_q[11:6], sel_q[4:1]};
  assign sel_ok  = !sel_q[0] && !sel_q[5] && (sel_q[DW-1:12] == '0) &&
                   (dec_idx < IDXW'(NLINES));
  assign wline   = dec_idx[LW-1:0];
  assign win_wr  = we && (addr == AW'(OFS_WIN)) && sel_ok;
  assign eoi     = we && (addr == AW'(OFS_EOI));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      ent_mask <= '1;
      ent_lvl  <= '0;
      tmr_mask <= 1'b1;
      tmr_line <= '0;
    end else begin
      if (we && addr == AW'(OFS_SEL)) sel_q <= wdata;
      if (we && addr == AW'(OFS_TMR)) begin
        tmr_mask <= wdata[TMR_MASK_BIT];
        tmr_line <= wdata[TSEL_W-1:0];
      end
      if (win_wr) begin
        ent_mask[wline] <= wdata[WIN_MASK_BIT];
        ent_lvl[wline]  <= wdata[WIN_LVL_BIT];
      end
    end
  end

  always_comb begin
    rd_c = '0;
    if (addr == AW'(OFS_SEL)) begin
      rd_c = sel_q;
    end else if (addr == AW'(OFS_WIN)) begin
      if (sel_ok) begin
        rd_c[WIN_MASK_BIT] = ent_mask[wline];
        rd_c[WIN_LVL_BIT]  = ent_lvl[wline];
      end
    end else if (addr == AW'(OFS_ISR)) begin
      rd_c[NLINES-1:0] = isr;
    end else if (addr == AW'(OFS_TMR)) begin
      rd_c[TMR_MASK_BIT]  = tmr_mask;
      rd_c[TSEL_W-1:0]    = tmr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_c;
  end

  // R7: an invalid select never changes any line entry
  assert_bad_sel_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(OFS_WIN) && !sel_ok) |=>
      ($stable(ent_mask) && $stable(ent_lvl)));
endmodule

// File: rtl/icc_pending.sv
module icc_pending #(
  parameter int NLINES = 32,
  parameter int TSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_in,
  input  logic              timer_evt,
  input  logic [NLINES-1:0] ent_mask,
  input  logic [NLINES-1:0] ent_lvl,
  input  logic              tmr_mask,
  input  logic [TSEL_W-1:0] tmr_line,
  input  logic [NLINES-1:0] ack_clr,
  output logic [NLINES-1:0] pend,
  output logic [NLINES-1:0] eff_mask
);
  logic [NLINES-1:0] in_q, in_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
      in_d <= '0;
    end else begin
      in_q <= irq_in;
      in_d <= in_q;
    end
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic is_tmr, src, hold;
    if (n < (1 << TSEL_W)) begin : g_tcap
      assign is_tmr = (tmr_line == TSEL_W'(n));
    end else begin : g_notmr
      assign is_tmr = 1'b0;
    end
    assign eff_mask[n] = is_tmr ? tmr_mask : ent_mask[n];
    assign src  = is_tmr ? timer_evt :
                  (ent_lvl[n] ? in_q[n] : (in_q[n] & ~in_d[n]));
    assign hold = is_tmr || !ent_lvl[n];

    always_ff @(posedge clk) begin
      if (rst)             pend[n] <= 1'b0;
      else if (ack_clr[n]) pend[n] <= 1'b0;
      else if (hold)       pend[n] <= pend[n] | (src & ~eff_mask[n]);
      else                 pend[n] <= src & ~eff_mask[n];
    end
  end
endmodule

// File: rtl/icc_service.sv
module icc_service #(
  parameter int NLINES   = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pend,
  input  logic [NLINES-1:0] eff_mask,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [NLINES-1:0] isr,
  output logic [NLINES-1:0] ack_clr
);
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;

  function automatic logic [LW-1:0] top_bit(input logic [NLINES-1:0] v);
    top_bit = '0;
    for (int i = 0; i < NLINES; i++) if (v[i]) top_bit = LW'(i);
  endfunction

  logic [NLINES-1:0] elig, eoi_clr;
  logic [LW-1:0]     top_p, top_s, cur_q;
  logic              any_p, any_s, req_c, take;

  assign elig    = pend & ~eff_mask;
  assign any_p   = |elig;
  assign any_s   = |isr;
  assign top_p   = top_bit(elig);
  assign top_s   = top_bit(isr);
  assign req_c   = any_p && (!any_s || top_p > top_s);
  assign take    = ack && irq_req;
  assign ack_clr = take ? (NLINES'(1) << cur_q) : '0;
  assign eoi_clr = (eoi && any_s) ? (NLINES'(1) << top_s) : '0;
  assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(cur_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      isr     <= '0;
      irq_req <= 1'b0;
      cur_q   <= '0;
    end else begin
      isr     <= (isr & ~eoi_clr) | ack_clr;
      irq_req <= req_c && !take;
      cur_q   <= top_p;
    end
  end

  // R3: the presented line is never one already in service
  assert_req_not_in_service_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !isr[cur_q]);
  // R4: presented vector lies above every in-service vector
  assert_no_lower_preempt_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_req && any_s) |-> (cur_q > top_s));
  // R11: acknowledge moves the line to service and drops the request
  assert_ack_moves_line_R11: assert property (@(posedge clk) disable iff (rst)
    take |=> (isr[$past(cur_q)] && !irq_req));
  // R5: end-of-interrupt removes exactly one in-service bit
  assert_eoi_clears_one_R5: assert property (@(posedge clk) disable iff (rst)
    (eoi && any_s && !take) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLINES   = 32,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int TSEL_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_in,
  input  logic              timer_evt,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack
);
  logic [NLINES-1:0] ent_mask, ent_lvl, isr, ack_clr, pend, eff_mask;
  logic              tmr_mask, eoi;
  logic [TSEL_W-1:0] tmr_line;

  icc_regs #(.NLINES(NLINES), .AW(AW), .DW(DW), .TSEL_W(TSEL_W)) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .re(bus_re), .isr(isr), .rdata(bus_rdata), .ent_mask(ent_mask),
    .ent_lvl(ent_lvl), .tmr_mask(tmr_mask), .tmr_line(tmr_line), .eoi(eoi));

  icc_pending #(.NLINES(NLINES), .TSEL_W(TSEL_W)) pend_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .timer_evt(timer_evt),
    .ent_mask(ent_mask), .ent_lvl(ent_lvl), .tmr_mask(tmr_mask),
    .tmr_line(tmr_line), .ack_clr(ack_clr), .pend(pend), .eff_mask(eff_mask));

  icc_service #(.NLINES(NLINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) svc_i (
    .clk(clk), .rst(rst), .pend(pend), .eff_mask(eff_mask), .ack(irq_ack),
    .eoi(eoi), .irq_req(irq_req), .irq_vec(irq_vector), .isr(isr),
    .ack_clr(ack_clr));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        timer_evt = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, irq_ack = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_flag = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .timer_evt(timer_evt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_ack(irq_ack));

  // monitor: read data is compared against the scoreboard queue
  always @(posedge clk) rd_flag <= bus_re;
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  function automatic logic [31:0] enc(input int n);
    return ((n & 32'h0F) << 1) | ((n & 32'hF0) << 2);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic set_line(input int n, input logic [31:0] v);
    wr(8'h00, enc(n)); wr(8'h04, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic er, input logic [7:0] ev, input string t);
    checks++;
    if (irq_req !== er || (er && irq_vector !== ev)) begin
      errors++;
      $display("FAIL %s: req=%b vec=%0d expected req=%b vec=%0d",
               t, irq_req, irq_vector, er, ev);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_in[n] = 1'b1;
    @(negedge clk); irq_in[n] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R2 reset state
    chk_irq(0, 0, "R2 reset irq");
    rd(8'h04, 32'h1, "R2 line0 masked at reset");
    rd(8'h0C, 32'h0, "R2 isr empty");
    rd(8'h10, 32'h0001_0000, "R2 timer reg reset");
    // R7 select encoding / R13 unimplemented bits
    wr(8'h00, enc(5)); wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, 32'h2, "R13 window upper bits zero");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R7 line5 entry via select");
    wr(8'h00, 32'h1); wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R7 invalid select reads zero");
    rd(8'h00, 32'h1, "R7 select reads back");
    wr(8'h00, 32'h20); wr(8'h04, 32'h0);
    wr(8'h00, enc(0));
    rd(8'h04, 32'h1, "R7 invalid select write ignored");
    // R8 masked line
    pulse(3); idle(3);
    chk_irq(0, 0, "R8 masked edge not presented");
    set_line(3, 32'h0); idle(3);
    chk_irq(0, 0, "R8 edge while masked forgotten");
    // R9 / R1 edge line 5
    pulse(5); idle(3);
    chk_irq(1, 8'd37, "R9 R1 edge line5 presented");
    // R11 acknowledge
    ack();
    chk_irq(0, 0, "R11 req low after ack");
    rd(8'h0C, 32'h0000_0020, "R6 R11 isr line5");
    // R4 lower held, R3 higher preempts
    set_line(2, 32'h0); pulse(2); idle(3);
    chk_irq(0, 0, "R4 lower line2 held");
    set_line(20, 32'h0); pulse(20); idle(3);
    chk_irq(1, 8'd52, "R3 line20 preempts");
    ack(); idle(1);
    rd(8'h0C, 32'h0010_0020, "R6 nested isr");
    // R5 end of interrupt
    wr(8'h08, 32'h0); idle(2);
    rd(8'h0C, 32'h0000_0020, "R5 eoi clears top only");
    chk_irq(0, 0, "R4 line2 still held");
    wr(8'h08, 32'hDEAD); idle(2);
    rd(8'h0C, 32'h0, "R5 second eoi");
    chk_irq(1, 8'd34, "R4 line2 after eoi");
    ack(); wr(8'h08, 32'h0); idle(2);
    chk_irq(0, 0, "R5 line2 retired");
    // R10 level mode on line 7
    set_line(7, 32'h2);
    @(negedge clk); irq_in[7] = 1'b1; idle(3);
    chk_irq(1, 8'd39, "R10 level presented");
    irq_in[7] = 1'b0; idle(3);
    chk_irq(0, 0, "R10 level withdrawn");
    irq_in[7] = 1'b1; idle(3);
    ack(); idle(2);
    chk_irq(0, 0, "R10 level in service");
    wr(8'h08, 32'h0); idle(2);
    chk_irq(1, 8'd39, "R10 level re-presented after eoi");
    irq_in[7] = 1'b0; idle(3);
    chk_irq(0, 0, "R10 level dropped");
    // R12 timer routing
    wr(8'h10, 32'hFFFF_FFF9);
    rd(8'h10, 32'h0001_0009, "R13 timer unused bits zero");
    wr(8'h10, 32'h9);
    @(negedge clk); timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0; idle(2);
    chk_irq(1, 8'd41, "R12 timer event presented");
    ack(); wr(8'h08, 32'h0); idle(2);
    wr(8'h10, 32'h0001_0009);
    @(negedge clk); timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0; idle(3);
    chk_irq(0, 0, "R12 masked timer ignored");
    set_line(9, 32'h0); pulse(9); idle(3);
    chk_irq(0, 0, "R12 external input on timer line ignored");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule